// File: doc/BRIEF.md
# Register List Stack Frame Sequencer

This block builds and tears down a procedure stack frame in several clock cycles. A caller hands it a 12-bit selection over the callee-saved registers r20..r31, a 5-bit local-area size counted in words, and a starting stack pointer. In the build operation the sequencer stores every selected register to memory one word per cycle, moving the stack pointer down, and then lowers the stack pointer further to reserve the local area. In the tear-down operation it first gives the local area back, then reloads the selected registers one word per cycle, moving the stack pointer up. Tear-down may also name a register whose value is handed out as the next fetch address.

The block drives a word-wide memory port whose read data arrives one cycle after the read request, and it reads and writes registers through a read port (combinational data) and a write port. Bit k of the selection stands for register 20+k. Unselected bits cost no cycle.

Top module: `lsf_frame_seq`

## Requirements
- R1: After reset `done_o`, `jump_valid_o`, `mem_we_o`, `mem_re_o` and `rf_we_o` are all low and the block accepts a start.
- R2: Build (`op_i`=0) stores each selected register (bit k means register 20+k) as one word at addresses SP-4, SP-8, ... with the lowest-numbered selected register at SP-4, the highest address of the frame.
- R3: Build ends with `sp_o` = SP - 4*(selected count) - 4*`imm_i`; the word at SP itself is not written.
- R4: Tear-down (`op_i`=1) raises SP by 4*`imm_i`, then loads words upward from there, the word at the lowest address going to the highest-numbered selected register, and ends with `sp_o` = SP + 4*`imm_i` + 4*(selected count).
- R5: Unselected registers take no memory cycle and no register write: build finishes in N+2 cycles, tear-down in N+3 cycles for N>0 and in 2 cycles for N=0, counted in clock edges from the accepting edge to `done_o`.
- R6: `done_o` is high for exactly one cycle per accepted start.
- R7: If `jreg_i` is nonzero on a tear-down, `jump_valid_o` is high together with `done_o` and `jump_addr_o` equals that register's value after all reloads; if it is zero, `jump_valid_o` stays low.
- R8: A start arriving while an operation is under way is ignored; the running operation's memory image, registers and final SP are unchanged by it.
- R9: During tear-down a register write of one loaded word and the read request for the next word take place in the same cycle, so every read is written back in the cycle after it was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| op_i | input | 1 | 0 build frame, 1 tear down frame |
| mask_i | input | 12 | Register selection, bit k = register 20+k |
| imm_i | input | 5 | Local area size in words |
| jreg_i | input | 5 | Jump register index for tear-down, 0 = none |
| sp_i | input | 32 | Stack pointer at start |
| sp_o | output | 32 | Working stack pointer, final value at done |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read request |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the request |
| rf_raddr_o | output | 5 | Register read index |
| rf_rdata_i | input | 32 | Register read data (same cycle) |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| done_o | output | 1 | One-cycle completion pulse |
| jump_valid_o | output | 1 | Jump target valid (with done) |
| jump_addr_o | output | 32 | Jump target value |

## Verification
In tear-down the write-back of one loaded word and the read request for the next word share a cycle. Runs with dense selections (all twelve bits, and adjacent bits at both ends) keep this overlap going for many cycles in a row; each register is preloaded with a distinct value and clobbered before reload, so any write landing on the wrong index or carrying the wrong word shows as a wrong register, and the cycle count from start to done shows whether the overlap really happened.

// File: rtl/lsf_pkg.sv
`timescale 1ns/1ps
package lsf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH    = 3'd1,
        ST_ALLOC   = 3'd2,
        ST_RELEASE = 3'd3,
        ST_POP     = 3'd4,
        ST_DONE    = 3'd5
    } lsf_state_e;

    localparam logic OP_BUILD    = 1'b0;
    localparam logic OP_TEARDOWN = 1'b1;
endpackage

// File: rtl/lsf_pick.sv
`timescale 1ns/1ps
// Priority picker over a selection vector; HIGH selects the variant.
module lsf_pick #(
    parameter int N    = 12,
    parameter bit HIGH = 1'b0,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    assign any_o = |vec_i;

    generate
        if (HIGH) begin : g_high
            always_comb begin
                idx_o = '0;
                for (int i = 0; i < N; i++) begin
                    if (vec_i[i]) idx_o = IW'(i);
                end
            end
        end else begin : g_low
            always_comb begin
                idx_o = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (vec_i[i]) idx_o = IW'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lsf_sp_adj.sv
`timescale 1ns/1ps
// Stack pointer adjust by a word count: raise or lower.
module lsf_sp_adj #(
    parameter int AW    = 32,
    parameter int IMMW  = 5,
    parameter int WBYTE = 4
) (
    input  logic [AW-1:0]   sp_i,
    input  logic [IMMW-1:0] words_i,
    input  logic            raise_i,
    output logic [AW-1:0]   sp_o
);
    logic [AW-1:0] bytes;
    assign bytes = AW'(words_i) * AW'(WBYTE);
    assign sp_o  = raise_i ? (sp_i + bytes) : (sp_i - bytes);
endmodule

// File: rtl/lsf_frame_seq.sv
`timescale 1ns/1ps
module lsf_frame_seq #(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int NREG     = 12,
    parameter int BASE_REG = 20,
    parameter int IMMW     = 5,
    parameter int RIDXW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_i,
    input  logic [NREG-1:0]  mask_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic [RIDXW-1:0] jreg_i,
    input  logic [AW-1:0]    sp_i,
    output logic [AW-1:0]    sp_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    output logic             mem_we_o,
    output logic             mem_re_o,
    input  logic [DW-1:0]    mem_rdata_i,
    output logic [RIDXW-1:0] rf_raddr_o,
    input  logic [DW-1:0]    rf_rdata_i,
    output logic             rf_we_o,
    output logic [RIDXW-1:0] rf_waddr_o,
    output logic [DW-1:0]    rf_wdata_o,
    output logic             done_o,
    output logic             jump_valid_o,
    output logic [AW-1:0]    jump_addr_o
);
    import lsf_pkg::*;

    localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int WBYTE = DW / 8;

    typedef struct packed {
        lsf_state_e       st;
        logic             op;
        logic [AW-1:0]    sp;
        logic [NREG-1:0]  rem;
        logic [IMMW-1:0]  imm;
        logic [RIDXW-1:0] jreg;
        logic             pend;
        logic [IW-1:0]    pend_idx;
    } seq_t;

    seq_t cur_q, nxt_d;

    // Build walks low index first, tear-down walks high index first.
    logic          lo_any, hi_any;
    logic [IW-1:0] lo_idx, hi_idx;

    lsf_pick #(.N(NREG), .HIGH(1'b0)) u_pick_lo (
        .vec_i (cur_q.rem),
        .any_o (lo_any),
        .idx_o (lo_idx)
    );

    lsf_pick #(.N(NREG), .HIGH(1'b1)) u_pick_hi (
        .vec_i (cur_q.rem),
        .any_o (hi_any),
        .idx_o (hi_idx)
    );

    logic [AW-1:0] sp_frame;

    lsf_sp_adj #(.AW(AW), .IMMW(IMMW), .WBYTE(WBYTE)) u_frame_adj (
        .sp_i    (cur_q.sp),
        .words_i (cur_q.imm),
        .raise_i (cur_q.st == ST_RELEASE),
        .sp_o    (sp_frame)
    );

    logic [AW-1:0] sp_dn, sp_up;
    assign sp_dn = cur_q.sp - AW'(WBYTE);
    assign sp_up = cur_q.sp + AW'(WBYTE);

    always_comb begin
        nxt_d        = cur_q;
        mem_addr_o   = '0;
        mem_wdata_o  = '0;
        mem_we_o     = 1'b0;
        mem_re_o     = 1'b0;
        rf_raddr_o   = '0;
        rf_we_o      = 1'b0;
        rf_waddr_o   = '0;
        rf_wdata_o   = '0;
        done_o       = 1'b0;
        jump_valid_o = 1'b0;
        jump_addr_o  = '0;

        unique case (cur_q.st)
            ST_IDLE: begin
                nxt_d.pend = 1'b0;
                if (start_i) begin
                    nxt_d.op   = op_i;
                    nxt_d.sp   = sp_i;
                    nxt_d.rem  = mask_i;
                    nxt_d.imm  = imm_i;
                    nxt_d.jreg = jreg_i;
                    if (op_i == OP_TEARDOWN) begin
                        nxt_d.st = ST_RELEASE;
                    end else if (|mask_i) begin
                        nxt_d.st = ST_PUSH;
                    end else begin
                        nxt_d.st = ST_ALLOC;
                    end
                end
            end

            ST_PUSH: begin
                rf_raddr_o  = RIDXW'(BASE_REG) + RIDXW'(lo_idx);
                mem_addr_o  = sp_dn;
                mem_wdata_o = rf_rdata_i;
                mem_we_o    = lo_any;
                if (lo_any) begin
                    nxt_d.sp          = sp_dn;
                    nxt_d.rem[lo_idx] = 1'b0;
                end
                if (!lo_any || ((cur_q.rem & ~(NREG'(1) << lo_idx)) == '0)) begin
                    nxt_d.st = ST_ALLOC;
                end
            end

            ST_ALLOC: begin
                nxt_d.sp = sp_frame;
                nxt_d.st = ST_DONE;
            end

            ST_RELEASE: begin
                nxt_d.sp = sp_frame;
                nxt_d.st = (|cur_q.rem) ? ST_POP : ST_DONE;
            end

            ST_POP: begin
                // write back the word requested last cycle
                if (cur_q.pend) begin
                    rf_we_o    = 1'b1;
                    rf_waddr_o = RIDXW'(BASE_REG) + RIDXW'(cur_q.pend_idx);
                    rf_wdata_o = mem_rdata_i;
                end
                // and request the next word in the same cycle
                if (hi_any) begin
                    mem_addr_o        = cur_q.sp;
                    mem_re_o          = 1'b1;
                    nxt_d.sp          = sp_up;
                    nxt_d.rem[hi_idx] = 1'b0;
                    nxt_d.pend        = 1'b1;
                    nxt_d.pend_idx    = hi_idx;
                end else begin
                    nxt_d.pend = 1'b0;
                    nxt_d.st   = ST_DONE;
                end
            end

            ST_DONE: begin
                done_o = 1'b1;
                if (cur_q.op == OP_TEARDOWN && cur_q.jreg != '0) begin
                    rf_raddr_o   = cur_q.jreg;
                    jump_valid_o = 1'b1;
                    jump_addr_o  = AW'(rf_rdata_i);
                end
                nxt_d.st = ST_IDLE;
            end

            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, op: 1'b0, sp: '0, rem: '0, imm: '0,
                       jreg: '0, pend: 1'b0, pend_idx: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sp_o = cur_q.sp;
endmodule

// File: rtl/lsf_frame_seq_chk.sv
`timescale 1ns/1ps
module lsf_frame_seq_chk #(
    parameter int AW    = 32,
    parameter int RIDXW = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_o,
    input logic             jump_valid_o,
    input logic             mem_we_o,
    input logic             mem_re_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic             rf_we_o
);
    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: consecutive stores descend by one word
    p_store_descend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - AW'(4)));

    // R4: consecutive loads ascend by one word
    p_load_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(4)));

    // R9: every read request is written back in the next cycle
    p_read_writeback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> rf_we_o);

    // R5: no cycle both stores and loads
    p_one_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    // R7: jump target only together with completion
    p_jump_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid_o |-> done_o);
endmodule

bind lsf_frame_seq lsf_frame_seq_chk #(.AW(AW), .RIDXW(RIDXW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_o       (done_o),
    .jump_valid_o (jump_valid_o),
    .mem_we_o     (mem_we_o),
    .mem_re_o     (mem_re_o),
    .mem_addr_o   (mem_addr_o),
    .rf_we_o      (rf_we_o)
);

// File: tb/lsf_frame_seq_tb.sv
`timescale 1ns/1ps
module lsf_frame_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [11:0] mask_i = '0;
    logic [4:0]  imm_i = '0;
    logic [4:0]  jreg_i = '0;
    logic [31:0] sp_i = '0;
    logic [31:0] sp_o, mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        mem_we_o, mem_re_o, rf_we_o, done_o, jump_valid_o;
    logic [4:0]  rf_raddr_o, rf_waddr_o;
    logic [31:0] rf_rdata_i, rf_wdata_o, jump_addr_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    lsf_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .mask_i(mask_i), .imm_i(imm_i), .jreg_i(jreg_i), .sp_i(sp_i),
        .sp_o(sp_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i),
        .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .done_o(done_o),
        .jump_valid_o(jump_valid_o), .jump_addr_o(jump_addr_o)
    );

    // Memory and register file models, each written by one process only.
    logic [31:0] mem [256];
    logic [31:0] rf  [32];
    logic        mem_fill_go = 1'b0;
    logic        rf_fill_go  = 1'b0;
    logic [23:0] rf_seed     = '0;
    logic [31:0] rd_q;

    always @(posedge clk) begin
        if (mem_fill_go) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'hDEAD_0000 | 32'(i);
        end else if (mem_we_o) begin
            mem[mem_addr_o[9:2]] <= mem_wdata_o;
        end
        rd_q <= mem[mem_addr_o[9:2]];
    end
    assign mem_rdata_i = rd_q;

    always @(posedge clk) begin
        if (rf_fill_go) begin
            for (int i = 0; i < 32; i++) rf[i] <= {rf_seed, 8'(i)};
        end else if (rf_we_o) begin
            rf[rf_waddr_o] <= rf_wdata_o;
        end
    end
    assign rf_rdata_i = rf[rf_raddr_o];

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fill_rf(input logic [23:0] seed);
        @(negedge clk); rf_seed = seed; rf_fill_go = 1'b1;
        @(negedge clk); rf_fill_go = 1'b0;
    endtask

    task automatic fill_mem();
        @(negedge clk); mem_fill_go = 1'b1;
        @(negedge clk); mem_fill_go = 1'b0;
    endtask

    // Runs one operation; returns the edge count to done, jump flags seen at done.
    task automatic run_op(input logic op, input logic [11:0] m, input logic [4:0] im,
                          input logic [4:0] jr, input logic [31:0] sp,
                          input bit inject, output int lat,
                          output logic jv, output logic [31:0] ja);
        @(negedge clk);
        op_i = op; mask_i = m; imm_i = im; jreg_i = jr; sp_i = sp; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 200) begin
            if (inject && lat == 1) begin
                op_i = ~op; mask_i = 12'hFFF; imm_i = 5'd9; jreg_i = 5'd1;
                sp_i = 32'h80; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        jv = jump_valid_o;
        ja = jump_addr_o;
        @(negedge clk);
        check(!done_o, "R6 done single pulse", 32'(done_o), 32'd0);
    endtask

    // Stimulus: mask, imm, jreg
    localparam int NVEC = 6;
    localparam logic [21:0] VEC [NVEC] = '{
        {12'hFFF, 5'd31, 5'd31},
        {12'h000, 5'd0,  5'd0 },
        {12'h801, 5'd3,  5'd20},
        {12'h2A4, 5'd7,  5'd2 },
        {12'h001, 5'd0,  5'd0 },
        {12'h0C3, 5'd1,  5'd23}
    };

    task automatic frame_pair(input logic [11:0] m, input logic [4:0] im,
                              input logic [4:0] jr, input bit inject);
        int lat, n, k;
        logic jv;
        logic [31:0] ja, sp0, spf, a;
        sp0 = 32'h0000_0200;
        n = 0;
        for (int i = 0; i < 12; i++) if (m[i]) n++;
        fill_mem();
        fill_rf(24'hA5A000 ^ {12'h0, m});
        run_op(1'b0, m, im, 5'd0, sp0, inject, lat, jv, ja);
        spf = sp0 - 32'(4 * n) - 32'(4 * im);
        check(lat == n + 2, "R5 build latency", 32'(lat), 32'(n + 2));
        check(sp_o == spf, "R3 build final sp", sp_o, spf);
        check(mem[sp0[9:2]] == (32'hDEAD_0000 | 32'(sp0[9:2])),
              "R3 word at sp untouched", mem[sp0[9:2]], 32'hDEAD_0000 | 32'(sp0[9:2]));
        k = 0;
        for (int i = 0; i < 12; i++) begin
            if (m[i]) begin
                a = sp0 - 32'(4 * (k + 1));
                check(mem[a[9:2]] == {24'hA5A000 ^ {12'h0, m}, 8'(20 + i)},
                      "R2 stored word", mem[a[9:2]], {24'hA5A000 ^ {12'h0, m}, 8'(20 + i)});
                k++;
            end
        end
        a = sp0 - 32'(4 * (n + 1));
        check(mem[a[9:2]] == (32'hDEAD_0000 | 32'(a[9:2])), "R5 no extra store",
              mem[a[9:2]], 32'hDEAD_0000 | 32'(a[9:2]));
        fill_rf(24'h333000);
        run_op(1'b1, m, im, jr, spf, inject, lat, jv, ja);
        check(lat == ((n == 0) ? 2 : n + 3), "R5 R9 teardown latency", 32'(lat),
              32'((n == 0) ? 2 : n + 3));
        check(sp_o == sp0, "R4 teardown final sp", sp_o, sp0);
        for (int i = 0; i < 12; i++) begin
            if (m[i])
                check(rf[20 + i] == {24'hA5A000 ^ {12'h0, m}, 8'(20 + i)},
                      "R4 R9 reloaded reg", rf[20 + i], {24'hA5A000 ^ {12'h0, m}, 8'(20 + i)});
            else
                check(rf[20 + i] == {24'h333000, 8'(20 + i)}, "R5 unselected reg kept",
                      rf[20 + i], {24'h333000, 8'(20 + i)});
        end
        check(jv == (jr != 0), "R7 jump valid", 32'(jv), 32'(jr != 0));
        if (jr != 0)
            check(ja == rf[jr], "R7 jump address", ja, rf[jr]);
    endtask

    initial begin
        fill_mem();
        repeat (3) @(negedge clk);
        check(!done_o && !jump_valid_o && !mem_we_o && !mem_re_o && !rf_we_o,
              "R1 reset outputs quiet",
              {27'd0, done_o, jump_valid_o, mem_we_o, mem_re_o, rf_we_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !mem_we_o && !mem_re_o, "R1 idle after reset",
              {29'd0, done_o, mem_we_o, mem_re_o}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            frame_pair(VEC[v][21:10], VEC[v][9:5], VEC[v][4:0], 1'b0);
        end

        // R8: starts during a running build and a running teardown are ignored
        frame_pair(12'h5A5, 5'd4, 5'd22, 1'b1);

        // R7: jump register outside the list, zero frame
        frame_pair(12'h000, 5'd5, 5'd7, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule